// File: doc/BRIEF.md
# Programmable Funnel and Barrel Shifter

This block is a purely combinational shifter for a WIDTH-bit datapath. One operand word is moved by a shift distance in a chosen direction, and a kind field sets what fills the vacated bit positions. The fill can be zeros, copies of the sign bit, or the bits that leave the other end (rotation). A fourth kind, the funnel, joins two words into one double-width value and returns a WIDTH-bit window from it. This covers extracting a field that straddles a word boundary and multi-word shifts.

The distance is decoded into one-hot tap selects, so exactly one distance drives the output at any time. All kinds share the same tap network. A right-window crossbar serves every operation: left shifts and the funnel use it on a bit-reversed source and reverse its result. There is no clock inside the block. The result settles in the same cycle as its inputs.

Top module: `funnel_barrel_shifter`

## Requirements
- R1: With `shift_kind` = 2'b00 (logical) and `shift_left` = 0, `y_word` equals `a_word` shifted right by `shift_amt`, with zeros entering at the most significant end.
- R2: The distance is decoded into WIDTH select lines, of which exactly one is active for each value of `shift_amt`. Every distance from 0 to WIDTH-1 produces its own correct result.
- R3: With `shift_kind` = 2'b00 and `shift_left` = 1, `y_word` equals `a_word` shifted left by `shift_amt`, with zeros entering at bit 0. This is `a_word` times 2^`shift_amt`, modulo 2^WIDTH.
- R4: With `shift_kind` = 2'b01 (arithmetic) and `shift_left` = 0, vacated upper positions take the value of `a_word[WIDTH-1]`. For example, a distance of WIDTH-1 gives all copies of the sign bit.
- R5: With `shift_kind` = 2'b01 and `shift_left` = 1, the result is the same as a logical left shift, with zero fill.
- R6: With `shift_kind` = 2'b10 (rotate), bits leaving one end re-enter at the other end. `shift_left` = 1 rotates toward the most significant bit, and `shift_left` = 0 rotates toward bit 0.
- R7: With `shift_kind` = 2'b11 (funnel), `y_word` equals bits [2*WIDTH-1-k : WIDTH-k] of the concatenation {`a_word`, `b_word`}, where k is `shift_amt`.
- R8: In funnel mode `shift_left` has no effect on `y_word`. In the other three modes `b_word` has no effect on `y_word`.
- R9: When `shift_amt` is zero, `y_word` equals `a_word` in every mode and direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | WIDTH | Word to shift; upper word of the funnel pair |
| b_word | input | WIDTH | Lower word of the funnel pair; unused otherwise |
| shift_amt | input | $clog2(WIDTH) | Shift distance k |
| shift_left | input | 1 | 1 = toward MSB, 0 = toward bit 0 |
| shift_kind | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 funnel |
| y_word | output | WIDTH | Shifted result |

## Verification
Fill selection and direction reversal act in the same evaluation. An arithmetic right shift of a negative word at the largest distance must come out as all sign copies. The same word with the direction flipped must instead show zero fill from bit 0. The bench provokes this pairing by sweeping every distance under every kind and both directions, using two operand patterns of opposite sign. Each result is judged against a model built from the language's own shift operators. Funnel requests with both direction values are compared against the same expected window, and a non-funnel request with a nonzero `b_word` is judged against a result that ignores it.

// File: rtl/shf_pkg.sv
// Package: shared encodings for the funnel/barrel shifter.
// Assumes the two-bit kind code is driven straight from the top port.
package shf_pkg;

    typedef enum logic [1:0] {
        SHF_LOGIC  = 2'b00,
        SHF_ARITH  = 2'b01,
        SHF_ROTATE = 2'b10,
        SHF_FUNNEL = 2'b11
    } shf_kind_e;

endpackage

// File: rtl/shf_amt_decode.sv
// Module: shf_amt_decode
// Turns a binary shift distance into WIDTH one-hot tap selects.
// Assumes WIDTH is a power of two so every code of amt names a tap.
module shf_amt_decode #(
    parameter int WIDTH = 16,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [AMT_W-1:0] amt,
    output logic [WIDTH-1:0] sel
);

    for (genvar d = 0; d < WIDTH; d++) begin : g_tap
        assign sel[d] = (amt == AMT_W'(d));
    end

    // Guard: exactly the addressed tap is active (R2).
    always_comb begin
        if (!$isunknown(amt)) begin
            p_sel_onehot_r2: assert ($onehot(sel) && sel[amt])
                else $error("tap select not one-hot for amt %0d", amt);
        end
    end

endmodule

// File: rtl/shf_source_prep.sv
// Module: shf_source_prep
// Builds the double-width source that the window crossbar reads.
// Right shifts present {fill, a}. Left shifts and the funnel present the
// bit reverse of {a, low}, so the same right window serves both directions.
// Assumes the caller reverses the window back whenever path_left is set.
module shf_source_prep
    import shf_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int EXT_W = 2 * WIDTH
) (
    input  shf_kind_e          kind,
    input  logic               to_left,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    output logic               path_left,
    output logic [EXT_W-1:0]   ext
);

    logic [WIDTH-1:0] upper_fill;
    logic [WIDTH-1:0] lower_fill;
    logic [EXT_W-1:0] base;
    logic [EXT_W-1:0] base_rev;

    // Funnel always extracts from the top, so it takes the left path.
    assign path_left = (kind == SHF_FUNNEL) || to_left;

    // Pick what enters above a for right shifts and below a for left shifts.
    always_comb begin
        unique case (kind)
            SHF_ARITH:  begin upper_fill = {WIDTH{a[WIDTH-1]}}; lower_fill = '0; end
            SHF_ROTATE: begin upper_fill = a;                   lower_fill = a;  end
            SHF_FUNNEL: begin upper_fill = '0;                  lower_fill = b;  end
            default:    begin upper_fill = '0;                  lower_fill = '0; end
        endcase
    end

    // Join the operand with its fill in the order the direction needs.
    always_comb begin
        if (path_left) base = {a, lower_fill};
        else           base = {upper_fill, a};
    end

    for (genvar i = 0; i < EXT_W; i++) begin : g_rev
        assign base_rev[i] = base[EXT_W-1-i];
    end

    // Present the reversed copy on the left path.
    assign ext = path_left ? base_rev : base;

endmodule

// File: rtl/shf_window_mux.sv
// Module: shf_window_mux
// Crossbar: each one-hot select gates one WIDTH-bit window of ext onto an
// OR bus. Assumes sel is one-hot, so exactly one window reaches win.
module shf_window_mux #(
    parameter int WIDTH = 16,
    localparam int EXT_W = 2 * WIDTH
) (
    input  logic [EXT_W-1:0] ext,
    input  logic [WIDTH-1:0] sel,
    output logic [WIDTH-1:0] win
);

    logic [WIDTH-1:0] tap [WIDTH];
    logic             unused_ext_top;

    // Window d covers ext[d+WIDTH-1:d]; the top ext bit is never reached.
    assign unused_ext_top = ext[EXT_W-1];

    for (genvar d = 0; d < WIDTH; d++) begin : g_win
        assign tap[d] = sel[d] ? ext[d +: WIDTH] : '0;
    end

    // OR the gated windows into the result.
    always_comb begin
        win = '0;
        for (int d = 0; d < WIDTH; d++) begin
            win = win | tap[d];
        end
    end

endmodule

// File: rtl/funnel_barrel_shifter.sv
// Module: funnel_barrel_shifter (top)
// Combinational shifter offering logical, arithmetic, rotate and two-word
// funnel operations over one one-hot tap network.
// Assumes WIDTH is a power of two. There is no state and no clock.
module funnel_barrel_shifter
    import shf_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int AMT_W = $clog2(WIDTH),
    localparam int EXT_W = 2 * WIDTH
) (
    input  logic [WIDTH-1:0] a_word,
    input  logic [WIDTH-1:0] b_word,
    input  logic [AMT_W-1:0] shift_amt,
    input  logic             shift_left,
    input  logic [1:0]       shift_kind,
    output logic [WIDTH-1:0] y_word
);

    shf_kind_e        kind;
    logic [WIDTH-1:0] sel;
    logic [EXT_W-1:0] ext;
    logic             path_left;
    logic [WIDTH-1:0] win;
    logic [WIDTH-1:0] win_rev;

    assign kind = shf_kind_e'(shift_kind);

    shf_amt_decode #(.WIDTH(WIDTH)) u_dec (
        .amt (shift_amt),
        .sel (sel)
    );

    shf_source_prep #(.WIDTH(WIDTH)) u_prep (
        .kind      (kind),
        .to_left   (shift_left),
        .a         (a_word),
        .b         (b_word),
        .path_left (path_left),
        .ext       (ext)
    );

    shf_window_mux #(.WIDTH(WIDTH)) u_mux (
        .ext (ext),
        .sel (sel),
        .win (win)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_out_rev
        assign win_rev[i] = win[WIDTH-1-i];
    end

    // Undo the source reversal on the left path.
    assign y_word = path_left ? win_rev : win;

    // Port-level guards on the settled result.
    always_comb begin
        if (!$isunknown({a_word, b_word, shift_amt, shift_left, shift_kind})) begin
            if (shift_amt == '0) begin
                p_zero_amt_pass_r9: assert (y_word == a_word)
                    else $error("zero distance changed the word");
            end
            if (kind == SHF_LOGIC && !shift_left && shift_amt != '0) begin
                p_lsr_msb_zero_r1: assert (y_word[WIDTH-1] == 1'b0)
                    else $error("logical right left a one in the MSB");
            end
            if ((kind == SHF_LOGIC || kind == SHF_ARITH) && shift_left && shift_amt != '0) begin
                p_lsl_lsb_zero_r3: assert (y_word[0] == 1'b0)
                    else $error("left shift left a one in bit 0");
            end
            if (kind == SHF_ARITH && !shift_left) begin
                p_asr_sign_keep_r4: assert (y_word[WIDTH-1] == a_word[WIDTH-1])
                    else $error("arithmetic right lost the sign");
            end
            if (kind == SHF_ROTATE) begin
                p_rot_popcount_r6: assert ($countones(y_word) == $countones(a_word))
                    else $error("rotation changed the number of ones");
            end
        end
    end

endmodule

// File: tb/funnel_barrel_shifter_test.sv
// Bench for funnel_barrel_shifter: a vector table, then swept and directed
// checks. Inputs change on the falling edge and outputs are read 2 ns later.
module funnel_barrel_shifter_test;

    localparam int W   = 16;
    localparam int AW  = 4;
    localparam int NV  = 12;

    logic          clk;
    logic          rst_n;
    logic [W-1:0]  a_word;
    logic [W-1:0]  b_word;
    logic [AW-1:0] shift_amt;
    logic          shift_left;
    logic [1:0]    shift_kind;
    logic [W-1:0]  y_word;

    int checks;
    int failures;
    bit done;

    funnel_barrel_shifter #(.WIDTH(W)) uut (
        .a_word     (a_word),
        .b_word     (b_word),
        .shift_amt  (shift_amt),
        .shift_left (shift_left),
        .shift_kind (shift_kind),
        .y_word     (y_word)
    );

    // 100 MHz clock
    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Vector fields: {kind[54:53], left[52], amt[51:48], a[47:32], b[31:16], expect[15:0]}
    localparam logic [54:0] VEC [NV] = '{
        {2'b00, 1'b0, 4'd4,  16'hF0F0, 16'h0000, 16'h0F0F},  // R1
        {2'b00, 1'b1, 4'd5,  16'h0003, 16'h0000, 16'h0060},  // R3
        {2'b01, 1'b0, 4'd15, 16'h8000, 16'h0000, 16'hFFFF},  // R4
        {2'b01, 1'b0, 4'd2,  16'h4000, 16'h0000, 16'h1000},  // R4
        {2'b01, 1'b1, 4'd1,  16'h8001, 16'h0000, 16'h0002},  // R5
        {2'b10, 1'b0, 4'd1,  16'h0001, 16'h0000, 16'h8000},  // R6
        {2'b10, 1'b1, 4'd4,  16'h8001, 16'h0000, 16'h0018},  // R6
        {2'b11, 1'b1, 4'd4,  16'h1234, 16'hABCD, 16'h234A},  // R7
        {2'b11, 1'b0, 4'd4,  16'h1234, 16'hABCD, 16'h234A},  // R8
        {2'b00, 1'b0, 4'd15, 16'h8000, 16'hFFFF, 16'h0001},  // R8
        {2'b01, 1'b0, 4'd0,  16'h8421, 16'h0000, 16'h8421},  // R9
        {2'b11, 1'b1, 4'd15, 16'h0001, 16'h8000, 16'hC000}   // R7
    };

    localparam string VEC_TAG [NV] = '{
        "R1", "R3", "R4", "R4", "R5", "R6", "R6", "R7", "R8", "R8", "R9", "R7"
    };

    // Expected result from the language's own shift operators.
    function automatic logic [W-1:0] ref_shift(input logic [1:0] kind, input logic left,
                                                 input int k, input logic [W-1:0] a,
                                                 input logic [W-1:0] b);
        logic signed [W-1:0] s;
        logic [2*W-1:0]      cat;
        logic [W-1:0]        r;
        case (kind)
            2'b00: r = left ? (a << k) : (a >> k);
            2'b01: begin
                if (left) r = a << k;
                else begin
                    s = a;
                    s = s >>> k;
                    r = s;
                end
            end
            2'b10: r = left ? ((a << k) | (a >> (W - k))) : ((a >> k) | (a << (W - k)));
            default: begin
                cat = {a, b} << k;
                r = cat[2*W-1:W];
            end
        endcase
        return r;
    endfunction

    function automatic string kind_tag(input logic [1:0] kind, input logic left, input int k);
        if (k == 0) return "R9";
        case (kind)
            2'b00: return left ? "R3" : "R1";
            2'b01: return left ? "R5" : "R4";
            2'b10: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] expv);
        checks++;
        if (y_word !== expv) begin
            failures++;
            $display("FAIL %s kind=%b left=%b amt=%0d a=%h b=%h actual=%h expected=%h",
                     tag, shift_kind, shift_left, shift_amt, a_word, b_word, y_word, expv);
        end
    endtask

    task automatic apply(input logic [1:0] kind, input logic left, input int k,
                         input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        shift_kind = kind;
        shift_left = left;
        shift_amt  = AW'(k);
        a_word     = a;
        b_word     = b;
        #2;
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        checks = 0; failures = 0; done = 0;
        rst_n = 1'b0;
        a_word = '0; b_word = '0; shift_amt = '0; shift_left = 1'b0; shift_kind = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        check("R9 reset-state", 16'h0000);
        rst_n = 1'b1;

        // Table walk
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v][54:53], VEC[v][52], int'(VEC[v][51:48]), VEC[v][47:32], VEC[v][31:16]);
            check(VEC_TAG[v], VEC[v][15:0]);
        end

        // Sweep: every kind, direction and distance, two opposite-sign patterns
        for (int p = 0; p < 2; p++) begin
            for (int kd = 0; kd < 4; kd++) begin
                for (int dl = 0; dl < 2; dl++) begin
                    for (int k = 0; k < W; k++) begin
                        logic [W-1:0] a;
                        logic [W-1:0] b;
                        a = (p == 0) ? 16'hB3C5 : 16'h7E81;
                        b = (p == 0) ? 16'h5A0F : 16'hC33C;
                        apply(2'(kd), dl[0], k, a, b);
                        check(kind_tag(2'(kd), dl[0], k), ref_shift(2'(kd), dl[0], k, a, b));
                    end
                end
            end
        end

        // R2: a single set bit lands at a distinct place for each distance
        for (int k = 0; k < W; k++) begin
            apply(2'b10, 1'b0, k, 16'h0001, 16'h0000);
            check("R2 one-tap", 16'(1 << ((W - k) % W)));
        end

        // R8: funnel ignores direction; other modes ignore b
        for (int k = 1; k < W; k += 5) begin
            apply(2'b11, 1'b0, k, 16'hCAFE, 16'h1357);
            check("R8 funnel-dir", ref_shift(2'b11, 1'b1, k, 16'hCAFE, 16'h1357));
            apply(2'b10, 1'b1, k, 16'h00F0, 16'hFFFF);
            check("R8 b-ignored", ref_shift(2'b10, 1'b1, k, 16'h00F0, 16'h0000));
            apply(2'b01, 1'b0, k, 16'h00F0, 16'hFFFF);
            check("R8 b-ignored", ref_shift(2'b01, 1'b0, k, 16'h00F0, 16'h0000));
        end

        // R4 corner: sign fill at the largest distance versus left zero fill (R5)
        apply(2'b01, 1'b0, W - 1, 16'hA000, 16'h0000);
        check("R4 max-dist", 16'hFFFF);
        apply(2'b01, 1'b1, W - 1, 16'hA001, 16'h0000);
        check("R5 max-dist", 16'h8000);

        done = 1;
        summary();
        $finish;
    end

endmodule